// File: doc/BRIEF.md
# Descriptor-Ring Parallel Transmit Engine

This block drains transmit buffers that software describes in a ring of 64-bit descriptors. The descriptors sit in a small 16-bit-wide memory. For each entry the engine reads the control half-word and checks that software has handed the entry over. It then reads the byte count and the buffer address, and fetches the buffer one byte at a time from a byte-wide memory. The bytes leave through a parallel output port, 8 or 16 bits wide, under a valid/ready handshake.

When a buffer has been sent, the engine rewrites only the control half-word, which returns the entry to software, and moves on to the next entry. An entry that has not been handed over raises a sticky error flag. A descriptor that breaks the length or alignment rules is closed with an error mark, and the engine then stops until software toggles the enable.

Descriptor word layout, in 16-bit words of the descriptor memory, for entry i: word 4i is control, word 4i+1 is the byte count, word 4i+2 holds the upper pointer half and word 4i+3 the lower pointer half. Control bits: bit 0 is ready (1 = owned by the engine), bit 1 is reserved, bit 2 is wrap, and bit 3 is the error mark written by the engine.

Top module: `ptx_tx_engine`

## Requirements
- R1: After reset, busy, the transmit error flag and tx_valid are low, and no descriptor write takes place.
- R2: Entry i is read at descriptor word addresses 4i (control), 4i+1 (byte count), 4i+2 (pointer bits 31:16) and 4i+3 (pointer bits 15:0). Memory reads return data one cycle after the address.
- R3: An entry whose control bit 0 is 0 sends no data and sets the sticky transmit error flag. The engine keeps polling that same entry. The flag clears only while the enable is low.
- R4: Buffer bytes are sent in ascending address order. With a 16-bit port, the lower-addressed byte of each pair is driven on data bits 15:8.
- R5: A beat transfers in a cycle where valid and ready are both high. While valid is high and ready is low, valid and data hold steady.
- R6: After the last beat, the engine writes the control word back with bits 0, 1 and 3 cleared and every other bit unchanged. The byte count and pointer words are never written.
- R7: After an entry with control bit 2 set, the next entry fetched is entry 0. Otherwise the next entry is the following one, and entry 0 follows the last entry of the ring.
- R8: With an 8-bit port, an odd byte count and an odd pointer are both accepted, and exactly byte-count beats are sent.
- R9: A byte count of zero, or with a 16-bit port an odd count or an odd pointer, sends no beat. The engine writes the control word with bit 0 cleared and bit 3 set, then ignores ready entries until the enable goes low and high again.
- R10: Raising the enable after it has been low starts polling at entry 0. Busy is high from the control-word fetch until the control write-back, and low while idle or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Engine enable; low returns polling to entry 0 and clears the error flag |
| dmem_addr_o | output | DAW | Descriptor memory word address |
| dmem_we_o | output | 1 | Descriptor memory write strobe (control write-back) |
| dmem_wdata_o | output | 16 | Descriptor memory write data |
| dmem_rdata_i | input | 16 | Descriptor memory read data, one cycle after the address |
| bmem_addr_o | output | BUF_AW | Buffer memory byte address |
| bmem_rdata_i | input | 8 | Buffer memory read data, one cycle after the address |
| tx_data_o | output | PORT_W | Outgoing data beat |
| tx_valid_o | output | 1 | Beat valid |
| tx_ready_i | input | 1 | Sink accepts beat |
| busy_o | output | 1 | Descriptor in progress |
| txe_o | output | 1 | Sticky error: reached an entry not handed over |

## Verification
The bench builds two copies of the block side by side. One has PORT_W=16 and the other PORT_W=8, and both use RING_N=8 and BUF_AW=8. The 16-bit copy exposes byte pairing onto the upper lane and the odd-length and odd-pointer rejections. The 8-bit copy reaches odd counts, odd pointers and the zero-count stop, which the wider port forbids. An eight-entry ring leaves spare entries after a wrap-marked entry, so a ready entry placed there shows whether the wrap bit was honoured. Each copy sees its own ready stall pattern, so held beats are exercised at both widths.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

   // control half-word bit positions (software-visible layout)
   localparam int unsigned BIT_RDY  = 0;
   localparam int unsigned BIT_RSV  = 1;
   localparam int unsigned BIT_WRAP = 2;
   localparam int unsigned BIT_ERR  = 3;

   typedef enum logic [3:0] {
      S_IDLE, S_ST, S_LEN, S_PH, S_PL, S_CHK,
      S_RD, S_CAP, S_SEND, S_WB, S_HALT
   } ptx_state_e;

   // control word handed back to software
   function automatic logic [15:0] close_ctrl(input logic [15:0] ctrl, input logic err);
      logic [15:0] r;
      r = ctrl;
      r[BIT_RDY] = 1'b0;
      r[BIT_RSV] = 1'b0;
      r[BIT_ERR] = err;
      return r;
   endfunction

endpackage

// File: rtl/ptx_ring_idx.sv
module ptx_ring_idx #(
   parameter int RING_N = 8,
   localparam int IDX_W = $clog2(RING_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic             wrap_i,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_N - 1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         idx_q <= '0;
      end else if (adv_i) begin
         if (wrap_i || idx_q == LAST) idx_q <= '0;
         else                         idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign idx_o = idx_q;

   // R7: a wrap-marked entry is followed by entry 0
   p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && wrap_i |=> idx_o == '0);

endmodule

// File: rtl/ptx_desc_check.sv
module ptx_desc_check #(
   parameter int PORT_W = 16
) (
   input  logic [15:0] len_i,
   input  logic        ptr_odd_i,
   output logic        bad_o
);

   generate
      if (PORT_W == 16) begin : g_wide
         // pairs only: count and start must both be even
         assign bad_o = (len_i == 16'd0) | len_i[0] | ptr_odd_i;
      end else begin : g_narrow
         // byte port: alignment is free, only an empty buffer is rejected
         assign bad_o = (len_i == 16'd0) | (ptr_odd_i & 1'b0);
      end
   endgenerate

endmodule

// File: rtl/ptx_beat_pack.sv
module ptx_beat_pack #(
   parameter int PORT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              cap_i,
   input  logic [7:0]        byte_i,
   output logic [PORT_W-1:0] data_o,
   output logic              last_o
);

   generate
      if (PORT_W == 16) begin : g_pair
         logic [7:0] hi_q, lo_q;
         logic       half_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hi_q   <= '0;
               lo_q   <= '0;
               half_q <= 1'b0;
            end else if (clr_i) begin
               half_q <= 1'b0;
            end else if (cap_i) begin
               if (!half_q) hi_q <= byte_i;   // lower address -> upper lane
               else         lo_q <= byte_i;
               half_q <= ~half_q;
            end
         end

         assign data_o = {hi_q, lo_q};
         assign last_o = half_q;
      end else begin : g_single
         logic [7:0] b_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr_i) b_q <= '0;
            else if (cap_i)      b_q <= byte_i;
         end

         assign data_o = b_q;
         assign last_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/ptx_tx_engine.sv
module ptx_tx_engine #(
   parameter int PORT_W = 16,
   parameter int RING_N = 8,
   parameter int BUF_AW = 16,
   localparam int DAW   = $clog2(RING_N) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   output logic [DAW-1:0]    dmem_addr_o,
   output logic              dmem_we_o,
   output logic [15:0]       dmem_wdata_o,
   input  logic [15:0]       dmem_rdata_i,
   output logic [BUF_AW-1:0] bmem_addr_o,
   input  logic [7:0]        bmem_rdata_i,
   output logic [PORT_W-1:0] tx_data_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i,
   output logic              busy_o,
   output logic              txe_o
);

   import ptx_pkg::*;

   localparam int IDX_W = $clog2(RING_N);
   localparam int LO_W  = (BUF_AW < 16) ? BUF_AW : 16;

   generate
      if (!(PORT_W == 8 || PORT_W == 16)) begin : g_bad_port
         $error("ptx_tx_engine: PORT_W must be 8 or 16");
      end
      if (RING_N < 2) begin : g_bad_ring
         $error("ptx_tx_engine: RING_N must be at least 2");
      end
      if (BUF_AW < 1 || BUF_AW > 32) begin : g_bad_aw
         $error("ptx_tx_engine: BUF_AW must be 1..32");
      end
   endgenerate

   ptx_state_e        state_q;
   logic [15:0]       ctrl_q, len_q, rem_q;
   logic [LO_W-1:0]   ptr_lo_q;
   logic [BUF_AW-1:0] ptr_w, cur_q;
   logic              err_q, txe_q;
   logic [IDX_W-1:0]  idx;
   logic [DAW-1:0]    base;
   logic              bad, pk_last;

   // ---------------- pointer assembly ----------------
   generate
      if (BUF_AW > 16) begin : g_ptr_hi
         logic [BUF_AW-17:0] ptr_hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                ptr_hi_q <= '0;
            else if (state_q == S_PH)  ptr_hi_q <= dmem_rdata_i[BUF_AW-17:0];
         end
         assign ptr_w = {ptr_hi_q, ptr_lo_q};
      end else begin : g_ptr_lo
         assign ptr_w = ptr_lo_q;
      end
   endgenerate

   // ---------------- sub-blocks ----------------
   ptx_ring_idx #(.RING_N(RING_N)) ring_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state_q == S_IDLE && !en_i),
      .adv_i  (state_q == S_WB),
      .wrap_i (ctrl_q[BIT_WRAP]),
      .idx_o  (idx)
   );

   ptx_desc_check #(.PORT_W(PORT_W)) chk_i (
      .len_i     (len_q),
      .ptr_odd_i (ptr_lo_q[0]),
      .bad_o     (bad)
   );

   ptx_beat_pack #(.PORT_W(PORT_W)) pack_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state_q == S_CHK),
      .cap_i  (state_q == S_CAP),
      .byte_i (bmem_rdata_i),
      .data_o (tx_data_o),
      .last_o (pk_last)
   );

   // ---------------- memory addressing ----------------
   assign base = {idx, 2'b00};

   always_comb begin
      case (state_q)
         S_ST:    dmem_addr_o = {idx, 2'd1};
         S_LEN:   dmem_addr_o = {idx, 2'd2};
         S_PH:    dmem_addr_o = {idx, 2'd3};
         default: dmem_addr_o = base;
      endcase
   end

   assign dmem_we_o    = (state_q == S_WB);
   assign dmem_wdata_o = close_ctrl(ctrl_q, err_q);
   assign bmem_addr_o  = cur_q;
   assign tx_valid_o   = (state_q == S_SEND);
   assign busy_o       = !(state_q == S_IDLE || state_q == S_HALT);
   assign txe_o        = txe_q;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         ctrl_q   <= '0;
         len_q    <= '0;
         rem_q    <= '0;
         ptr_lo_q <= '0;
         cur_q    <= '0;
         err_q    <= 1'b0;
         txe_q    <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (!en_i) txe_q   <= 1'b0;
               else       state_q <= S_ST;
            end
            S_ST: begin
               if (!dmem_rdata_i[BIT_RDY]) begin
                  txe_q   <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  ctrl_q  <= dmem_rdata_i;
                  state_q <= S_LEN;
               end
            end
            S_LEN: begin
               len_q   <= dmem_rdata_i;
               state_q <= S_PH;
            end
            S_PH: state_q <= S_PL;
            S_PL: begin
               ptr_lo_q <= dmem_rdata_i[LO_W-1:0];
               state_q  <= S_CHK;
            end
            S_CHK: begin
               err_q   <= bad;
               cur_q   <= ptr_w;
               rem_q   <= len_q;
               state_q <= bad ? S_WB : S_RD;
            end
            S_RD: state_q <= S_CAP;
            S_CAP: begin
               cur_q   <= cur_q + BUF_AW'(1);
               rem_q   <= rem_q - 16'd1;
               state_q <= (pk_last || rem_q == 16'd1) ? S_SEND : S_RD;
            end
            S_SEND: begin
               if (tx_ready_i) state_q <= (rem_q == 16'd0) ? S_WB : S_RD;
            end
            S_WB: state_q <= err_q ? S_HALT : S_IDLE;
            S_HALT: begin
               if (!en_i) state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   // R10: a beat is only offered while a descriptor is in progress
   p_valid_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> busy_o);

   // R5: a stalled beat holds
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

   // R6: only the control word is written, and it is returned to software
   p_wb_ctrl_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we_o |-> dmem_addr_o[1:0] == 2'b00 && !dmem_wdata_o[BIT_RDY]
                    && !dmem_wdata_o[BIT_RSV]);

   // R3: error flag cannot drop while enabled
   p_txe_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      txe_o && en_i |=> txe_o);

   // R9: a stopped engine neither sends nor writes
   p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == S_HALT |=> !tx_valid_o && !dmem_we_o);

endmodule

// File: tb/ptx_tb_lane.sv
module ptx_tb_lane #(
   parameter int PORT_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        tb_dwe,
   input  logic [4:0]  tb_da,
   input  logic [15:0] tb_dwd,
   output logic [15:0] tb_drd,
   input  logic        tb_bwe,
   input  logic [7:0]  tb_ba,
   input  logic [7:0]  tb_bwd,
   output logic [15:0] txd,
   output logic        txv,
   input  logic        txr,
   output logic        busy,
   output logic        txe
);

   logic [15:0]       dm [32];
   logic [7:0]        bm [256];
   logic [4:0]        da;
   logic              dwe;
   logic [15:0]       dwd, drd;
   logic [7:0]        ba, brd;
   logic [PORT_W-1:0] txd_n;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++)  dm[i] <= '0;
         for (int i = 0; i < 256; i++) bm[i] <= '0;
      end else begin
         if (dwe)    dm[da]    <= dwd;
         if (tb_dwe) dm[tb_da] <= tb_dwd;
         if (tb_bwe) bm[tb_ba] <= tb_bwd;
      end
      drd <= dm[da];
      brd <= bm[ba];
   end

   assign tb_drd = dm[tb_da];
   assign txd    = 16'(txd_n);

   ptx_tx_engine #(.PORT_W(PORT_W), .RING_N(8), .BUF_AW(8)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en),
      .dmem_addr_o  (da),
      .dmem_we_o    (dwe),
      .dmem_wdata_o (dwd),
      .dmem_rdata_i (drd),
      .bmem_addr_o  (ba),
      .bmem_rdata_i (brd),
      .tx_data_o    (txd_n),
      .tx_valid_o   (txv),
      .tx_ready_i   (txr),
      .busy_o       (busy),
      .txe_o        (txe)
   );

endmodule

// File: tb/ptx_tx_engine_tb_top.sv
module ptx_tx_engine_tb_top;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic        en   [2];
   logic        dwe  [2];
   logic [4:0]  da   [2];
   logic [15:0] dwd  [2];
   logic [15:0] drv  [2];
   logic        bwe  [2];
   logic [7:0]  ba   [2];
   logic [7:0]  bwd  [2];
   logic [15:0] txd  [2];
   logic        txv  [2];
   logic        rdy  [2];
   logic        busy [2];
   logic        txe  [2];

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   logic [15:0] q0[$];
   logic [15:0] q1[$];

   ptx_tb_lane #(.PORT_W(16)) lane16_i (
      .clk(clk), .rst_n(rst_n), .en(en[0]),
      .tb_dwe(dwe[0]), .tb_da(da[0]), .tb_dwd(dwd[0]), .tb_drd(drv[0]),
      .tb_bwe(bwe[0]), .tb_ba(ba[0]), .tb_bwd(bwd[0]),
      .txd(txd[0]), .txv(txv[0]), .txr(rdy[0]), .busy(busy[0]), .txe(txe[0]));

   ptx_tb_lane #(.PORT_W(8)) lane8_i (
      .clk(clk), .rst_n(rst_n), .en(en[1]),
      .tb_dwe(dwe[1]), .tb_da(da[1]), .tb_dwd(dwd[1]), .tb_drd(drv[1]),
      .tb_bwe(bwe[1]), .tb_ba(ba[1]), .tb_bwd(bwd[1]),
      .txd(txd[1]), .txv(txv[1]), .txr(rdy[1]), .busy(busy[1]), .txe(txe[1]));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] bval(input int ln, input int a);
      return 8'(a * 5 + ln * 17 + 1);
   endfunction

   task automatic dwr(input int ln, input int a, input logic [15:0] d);
      @(negedge clk);
      da[ln] = 5'(a); dwd[ln] = d; dwe[ln] = 1'b1;
      @(negedge clk);
      dwe[ln] = 1'b0;
   endtask

   task automatic bwr(input int ln, input int a, input logic [7:0] d);
      @(negedge clk);
      ba[ln] = 8'(a); bwd[ln] = d; bwe[ln] = 1'b1;
      @(negedge clk);
      bwe[ln] = 1'b0;
   endtask

   task automatic drd(input int ln, input int a, output logic [15:0] v);
      @(negedge clk);
      da[ln] = 5'(a);
      #1 v = drv[ln];
   endtask

   // driver: writes buffer, count, pointer, pushes expected beats, then hands over
   task automatic put_desc(input int ln, input int idx, input logic [15:0] st,
                           input int len, input int ptr, input bit push);
      for (int k = 0; k < len; k++) bwr(ln, ptr + k, bval(ln, ptr + k));
      dwr(ln, idx * 4 + 1, 16'(len));
      dwr(ln, idx * 4 + 2, 16'h0000);
      dwr(ln, idx * 4 + 3, 16'(ptr));
      if (push) begin
         if (ln == 0)
            for (int k = 0; k < len; k += 2) q0.push_back({bval(0, ptr + k), bval(0, ptr + k + 1)});
         else
            for (int k = 0; k < len; k++) q1.push_back({8'h00, bval(1, ptr + k)});
      end
      dwr(ln, idx * 4, st);
   endtask

   task automatic wait_done(input int ln, input int idx, input string req);
      logic [15:0] v;
      bit done = 1'b0;
      for (int t = 0; t < 3000 && !done; t++) begin
         drd(ln, idx * 4, v);
         if (!v[0]) done = 1'b1;
      end
      chk(done, req, "entry not returned", 32'(done), 1);
   endtask

   task automatic chk_word(input int ln, input int a, input logic [15:0] exp,
                           input string req, input string what);
      logic [15:0] v;
      drd(ln, a, v);
      chk(v == exp, req, what, 32'(v), 32'(exp));
   endtask

   // monitor: picks ready, pops the scoreboard on each transfer
   always @(negedge clk) begin
      logic [15:0] e;
      cyc++;
      rdy[0] = (cyc % 3) != 2;
      rdy[1] = (cyc % 4) != 1;
      if (rst_n && txv[0] && rdy[0]) begin
         chk(busy[0], "R10", "lane16 busy during beat", 32'(busy[0]), 1);
         if (q0.size() == 0) chk(1'b0, "R4", "lane16 unexpected beat", 32'(txd[0]), 0);
         else begin
            e = q0.pop_front();
            chk(txd[0] == e, "R4", "lane16 beat", 32'(txd[0]), 32'(e));
         end
      end
      if (rst_n && txv[1] && rdy[1]) begin
         if (q1.size() == 0) chk(1'b0, "R8", "lane8 unexpected beat", 32'(txd[1]), 0);
         else begin
            e = q1.pop_front();
            chk(txd[1] == e, "R8", "lane8 beat", 32'(txd[1]), 32'(e));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog expired: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int l = 0; l < 2; l++) begin
         en[l] = 1'b0; dwe[l] = 1'b0; bwe[l] = 1'b0;
         da[l] = '0; dwd[l] = '0; ba[l] = '0; bwd[l] = '0;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset
      chk(!busy[0] && !txv[0] && !txe[0], "R1", "lane16 idle", {busy[0], txv[0], txe[0]}, 0);
      chk(!busy[1] && !txv[1] && !txe[1], "R1", "lane8 idle", {busy[1], txv[1], txe[1]}, 0);
      chk_word(0, 0, 16'h0000, "R1", "no write during reset");

      // lane16: entry0 with reserved + user bit, entry1 wrap, entry2 must stay untouched
      put_desc(0, 0, 16'h0103, 6, 16'h10, 1'b1);
      put_desc(0, 1, 16'h0005, 4, 16'h20, 1'b1);
      put_desc(0, 2, 16'h0001, 2, 16'h28, 1'b0);
      // lane8: odd count+pointer, single byte, zero count, a ready entry after the stop
      put_desc(1, 0, 16'h0001, 3, 16'h31, 1'b1);
      put_desc(1, 1, 16'h0001, 1, 16'h40, 1'b1);
      put_desc(1, 2, 16'h0001, 0, 16'h50, 1'b0);
      put_desc(1, 3, 16'h0001, 1, 16'h60, 1'b0);
      @(negedge clk);
      en[0] = 1'b1; en[1] = 1'b1;

      wait_done(0, 1, "R7");
      wait_done(1, 2, "R9");
      repeat (60) @(negedge clk);
      chk_word(0, 0, 16'h0100, "R6", "lane16 ctrl0 returned, user bit kept");
      chk_word(0, 1, 16'h0006, "R6", "lane16 count0 untouched");
      chk_word(0, 3, 16'h0010, "R2", "lane16 pointer0 untouched");
      chk_word(0, 4, 16'h0004, "R7", "lane16 ctrl1 keeps wrap");
      chk_word(0, 8, 16'h0001, "R7", "lane16 entry2 skipped by wrap");
      chk(txe[0], "R3", "lane16 flag after wrap to returned entry", 32'(txe[0]), 1);
      chk(q0.size() == 0, "R4", "lane16 beats left", q0.size(), 0);
      chk_word(1, 0, 16'h0000, "R8", "lane8 odd entry returned");
      chk_word(1, 8, 16'h0008, "R9", "lane8 zero count marked");
      chk_word(1, 9, 16'h0000, "R6", "lane8 zero count untouched");
      chk_word(1, 12, 16'h0001, "R9", "lane8 stopped before entry3");
      chk(!busy[1] && !txe[1], "R9", "lane8 stopped quietly", {busy[1], txe[1]}, 0);
      chk(q1.size() == 0, "R8", "lane8 beats left", q1.size(), 0);

      // R3: flag clears with enable low
      en[0] = 1'b0;
      repeat (3) @(negedge clk);
      chk(!txe[0], "R3", "lane16 flag cleared", 32'(txe[0]), 0);

      // R9: odd count on the wide port
      put_desc(0, 0, 16'h0001, 5, 16'h10, 1'b0);
      en[0] = 1'b1;
      wait_done(0, 0, "R9");
      repeat (10) @(negedge clk);
      chk_word(0, 0, 16'h0008, "R9", "lane16 odd count marked");
      chk(!busy[0] && !txe[0], "R9", "lane16 stopped", {busy[0], txe[0]}, 0);

      // R9: odd pointer on the wide port
      en[0] = 1'b0;
      repeat (3) @(negedge clk);
      put_desc(0, 0, 16'h0001, 4, 16'h11, 1'b0);
      en[0] = 1'b1;
      wait_done(0, 0, "R9");
      repeat (10) @(negedge clk);
      chk_word(0, 0, 16'h0008, "R9", "lane16 odd pointer marked");

      // R10: re-enable restarts at entry 0 (entry1 is not handed over)
      en[0] = 1'b0;
      repeat (3) @(negedge clk);
      put_desc(0, 0, 16'h0001, 2, 16'h70, 1'b1);
      en[0] = 1'b1;
      wait_done(0, 0, "R10");
      repeat (20) @(negedge clk);
      chk_word(0, 0, 16'h0000, "R10", "lane16 restart entry0 returned");
      chk(txe[0], "R3", "lane16 polls entry1 not handed over", 32'(txe[0]), 1);
      chk(q0.size() == 0, "R4", "lane16 restart beats left", q0.size(), 0);

      // R8/R10: lane8 restart with odd pointer
      en[1] = 1'b0;
      repeat (3) @(negedge clk);
      put_desc(1, 0, 16'h0001, 2, 16'h33, 1'b1);
      en[1] = 1'b1;
      wait_done(1, 0, "R10");
      repeat (20) @(negedge clk);
      chk_word(1, 0, 16'h0000, "R10", "lane8 restart entry0 returned");
      chk(q1.size() == 0, "R8", "lane8 restart beats left", q1.size(), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule